// File: doc/BRIEF.md
# Presettable Synchronous Up/Down Counter

This block is a four-stage counter that can be preset and that counts up or down, with every change of state taken on the rising clock edge. A parameter selects whether it steps through the ten decimal digits or through all sixteen binary codes. A synchronous load strobe presets the counter from a data word. Two active-low enables allow counting. One enable gates only the counting step. The other also gates the terminal-count output.

The active-low terminal count is decoded combinationally from the current state, the direction select and the trickle enable. Several counters can therefore be chained by feeding each stage's terminal count into the trickle enable of the next stage, and the carry looks ahead through the chain within the same cycle. In decimal mode the six unused codes lead back into the legal sequence, so a stage that is loaded or reset into garbage recovers after at most two counting edges.

Top module: `udc_counter`

## Requirements
- R1: When `load_n` is low at a rising edge, `q` takes the value of `din` on that edge, whatever `en_par_n`, `en_tri_n` and `up` are.
- R2: With `load_n` high, both enables low and `up` high, a rising edge increments `q`.
- R3: With `load_n` high, both enables low and `up` low, a rising edge decrements `q`.
- R4: With `load_n` high and either enable high, `q` keeps its value across the edge.
- R5: `tc_n` is high whenever `en_tri_n` is high.
- R6: `tc_n` does not depend on `en_par_n`.
- R7: With `en_tri_n` low and `up` high, `tc_n` is low when `q` holds the top code: 15 in binary mode, 9 in decimal mode.
- R8: With `en_tri_n` low and `up` low, `tc_n` is low exactly when `q` is 0.
- R9: In binary mode, counting up wraps from 15 to 0, and counting down wraps from 0 to 15.
- R10: In decimal mode, counting up steps through 0 to 9 and then back to 0.
- R11: In decimal mode, counting down steps from 9 down to 0 and then back to 9.
- R12: In decimal mode with `up` high and `en_tri_n` low, `tc_n` is also low at the unused codes 11, 13 and 15, because the up decode tests only bit 0 and bit 3.
- R13: In decimal mode, counting up from an unused code takes 10 to 11, 12 to 13 and 14 to 15, and takes 11, 13 and 15 to 0. Counting down from any code from 10 to 15 gives 9.
- R14: While `rst_n` is low at a rising edge, `q` becomes 0, taking priority over a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes occur on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset to 0 |
| load_n | input | 1 | Active-low parallel load strobe |
| din | input | WIDTH | Parallel preset data |
| en_par_n | input | 1 | Active-low count enable; gates counting only |
| en_tri_n | input | 1 | Active-low count enable; gates counting and terminal count |
| up | input | 1 | Direction select: 1 counts up, 0 counts down |
| q | output | WIDTH | Counter state |
| tc_n | output | 1 | Active-low terminal count (combinational) |

## Verification
The bench builds one instance with DECADE=1 and WIDTH=4. This instance reaches the decimal wrap in both directions and the unused codes 10 to 15 through the load path, which covers the recovery steps and the spurious terminal count at odd unused codes. Two further instances with DECADE=0 and WIDTH=4 are chained into an 8-bit counter, the upper stage's trickle enable taken from the lower stage's terminal count. This chain exercises the binary wrap of each stage and the carry and borrow that cross between stages, checked against an 8-bit reference count in both directions.

// File: rtl/udc_pkg.sv
// Shared types for the up/down counter.
// Assumes: nothing beyond IEEE 1800-2017.
package udc_pkg;
    // Action selected for the next rising clock edge.
    typedef enum logic [1:0] {
        UDC_HOLD = 2'd0,
        UDC_LOAD = 2'd1,
        UDC_INC  = 2'd2,
        UDC_DEC  = 2'd3
    } udc_op_e;
endpackage

// File: rtl/udc_ctrl.sv
// Mode decoder: turns the active-low strobes and the direction select into
// one action. Load wins over counting, and counting needs both enables low.
// Assumes: inputs are synchronous to the counter clock.
module udc_ctrl
    import udc_pkg::*;
(
    input  logic    load_n,
    input  logic    en_par_n,
    input  logic    en_tri_n,
    input  logic    up,
    output udc_op_e op
);
    // Priority decode: load, then count, else hold.
    always_comb begin
        if (!load_n)
            op = UDC_LOAD;
        else if (!en_par_n && !en_tri_n)
            op = up ? UDC_INC : UDC_DEC;
        else
            op = UDC_HOLD;
    end
endmodule

// File: rtl/udc_next.sv
// Next-state logic. DECADE picks a decimal sequence with recovery from the
// unused codes, or a plain modulo-2^WIDTH binary sequence.
// Assumes: WIDTH is 4 when DECADE is 1.
module udc_next
    import udc_pkg::*;
#(
    parameter int WIDTH  = 4,
    parameter bit DECADE = 1'b0
) (
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] din,
    input  udc_op_e          op,
    output logic [WIDTH-1:0] nxt
);
    localparam logic [WIDTH-1:0] TOP_DEC = WIDTH'(9);
    localparam logic [WIDTH-1:0] ONE     = WIDTH'(1);

    logic [WIDTH-1:0] inc_v;
    logic [WIDTH-1:0] dec_v;

    generate
        if (DECADE) begin : g_dec
            // Decimal increment: 9 and odd unused codes go to 0, even unused codes step.
            always_comb begin
                if (cur == TOP_DEC)
                    inc_v = '0;
                else if (cur > TOP_DEC && cur[0])
                    inc_v = '0;
                else
                    inc_v = cur + ONE;
            end
            // Decimal decrement: 0 and every unused code go to 9.
            always_comb begin
                if (cur == '0 || cur > TOP_DEC)
                    dec_v = TOP_DEC;
                else
                    dec_v = cur - ONE;
            end
        end else begin : g_bin
            // Binary step: natural wrap in both directions.
            always_comb begin
                inc_v = cur + ONE;
                dec_v = cur - ONE;
            end
        end
    endgenerate

    // Select the action result.
    always_comb begin
        unique case (op)
            UDC_LOAD: nxt = din;
            UDC_INC:  nxt = inc_v;
            UDC_DEC:  nxt = dec_v;
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/udc_tc.sv
// Terminal-count decode, combinational so that chained stages see the
// carry within the same cycle. The parallel enable has no effect on it.
// Assumes: WIDTH is 4 when DECADE is 1 (up decode uses the top and bottom bits).
module udc_tc #(
    parameter int WIDTH  = 4,
    parameter bit DECADE = 1'b0
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             en_tri_n,
    input  logic             up,
    output logic             tc_n
);
    logic at_top;

    generate
        if (DECADE) begin : g_dec
            // Sparse decode of 9: also true at 11, 13 and 15.
            always_comb at_top = cur[0] & cur[WIDTH-1];
        end else begin : g_bin
            // All ones.
            always_comb at_top = &cur;
        end
    endgenerate

    // Gate the end-state hit with the trickle enable and invert.
    always_comb begin
        if (up)
            tc_n = ~(~en_tri_n & at_top);
        else
            tc_n = ~(~en_tri_n & ~|cur);
    end
endmodule

// File: rtl/udc_counter.sv
// Presettable synchronous up/down counter. The state register changes only
// on the rising clock edge, with a synchronous active-low reset to 0. The
// terminal count is combinational, for look-ahead chaining.
// Assumes: WIDTH is 4 when DECADE is 1.
module udc_counter
    import udc_pkg::*;
#(
    parameter int WIDTH  = 4,
    parameter bit DECADE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic [WIDTH-1:0] din,
    input  logic             en_par_n,
    input  logic             en_tri_n,
    input  logic             up,
    output logic [WIDTH-1:0] q,
    output logic             tc_n
);
    localparam logic [WIDTH-1:0] TOP_CODE = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};

    udc_op_e          op;
    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] state_d;

    udc_ctrl u_ctrl (
        .load_n   (load_n),
        .en_par_n (en_par_n),
        .en_tri_n (en_tri_n),
        .up       (up),
        .op       (op)
    );

    udc_next #(.WIDTH(WIDTH), .DECADE(DECADE)) u_next (
        .cur (state_q),
        .din (din),
        .op  (op),
        .nxt (state_d)
    );

    udc_tc #(.WIDTH(WIDTH), .DECADE(DECADE)) u_tc (
        .cur      (state_q),
        .en_tri_n (en_tri_n),
        .up       (up),
        .tc_n     (tc_n)
    );

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign q = state_q;

    // Load copies the data word on the next edge.
    assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> q == $past(din));

    // Any enable high with no load leaves the state unchanged.
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && (en_par_n || en_tri_n)) |=> $stable(q));

    // Trickle enable high forces terminal count inactive.
    assert_tc_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        en_tri_n |-> tc_n);

    // Top code reached while counting up asserts terminal count.
    assert_tc_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_tri_n && up && q == TOP_CODE) |-> !tc_n);

    // Zero reached while counting down asserts terminal count.
    assert_tc_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_tri_n && !up) |-> (tc_n == (q != '0)));

    // Reset clears the state.
    assert_reset_R14: assert property (@(posedge clk)
        !rst_n |=> q == '0);

    generate
        if (DECADE) begin : g_chk_dec
            // Counting up from a legal digit stays legal.
            assert_dec_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
                (op == UDC_INC && q <= WIDTH'(9)) |=> q <= WIDTH'(9));
            // Counting down from an unused code lands on 9.
            assert_dec_down_R13: assert property (@(posedge clk) disable iff (!rst_n)
                (op == UDC_DEC && q > WIDTH'(9)) |=> q == WIDTH'(9));
            // Counting up from an odd unused code lands on 0.
            assert_dec_up_R13: assert property (@(posedge clk) disable iff (!rst_n)
                (op == UDC_INC && q > WIDTH'(9) && q[0]) |=> q == '0);
        end else begin : g_chk_bin
            // Binary increment with wrap.
            assert_bin_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (op == UDC_INC) |=> q == WIDTH'($past(q) + 1'b1));
            // Binary decrement with wrap.
            assert_bin_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (op == UDC_DEC) |=> q == WIDTH'($past(q) - 1'b1));
        end
    endgenerate
endmodule

// File: tb/tb_udc_counter.sv
module tb_udc_counter;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    // Decimal instance stimulus.
    logic       load_n = 1'b1;
    logic [3:0] din = '0;
    logic       ep_n = 1'b1;
    logic       et_n = 1'b1;
    logic       up = 1'b1;
    logic [3:0] q_d;
    logic       tc_d;
    // Binary chain stimulus.
    logic       c_load_n = 1'b1;
    logic [7:0] c_din = '0;
    logic       c_en_n = 1'b1;
    logic       c_up = 1'b1;
    logic [3:0] q_lo, q_hi;
    logic       tc_lo, tc_hi;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    udc_counter #(.WIDTH(4), .DECADE(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din),
        .en_par_n(ep_n), .en_tri_n(et_n), .up(up), .q(q_d), .tc_n(tc_d)
    );

    udc_counter #(.WIDTH(4), .DECADE(1'b0)) dut_bin_lo (
        .clk(clk), .rst_n(rst_n), .load_n(c_load_n), .din(c_din[3:0]),
        .en_par_n(c_en_n), .en_tri_n(c_en_n), .up(c_up), .q(q_lo), .tc_n(tc_lo)
    );

    udc_counter #(.WIDTH(4), .DECADE(1'b0)) dut_bin_hi (
        .clk(clk), .rst_n(rst_n), .load_n(c_load_n), .din(c_din[7:4]),
        .en_par_n(c_en_n), .en_tri_n(tc_lo), .up(c_up), .q(q_hi), .tc_n(tc_hi)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One rising edge, returning at the following falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load_dec(input int v);
        load_n = 1'b0; din = 4'(v);
        step();
        load_n = 1'b1;
    endtask

    task automatic test_reset();
        rst_n = 1'b0; load_n = 1'b0; din = 4'd7;
        c_load_n = 1'b0; c_din = 8'hA5;
        step();
        check("R14 reset over load (decimal)", q_d, 0);
        check("R14 reset over load (chain)", {q_hi, q_lo}, 0);
        rst_n = 1'b1; load_n = 1'b1; c_load_n = 1'b1;
    endtask

    task automatic test_load();
        ep_n = 1'b1; et_n = 1'b1; up = 1'b0;
        load_dec(5);
        check("R1 load with enables off", q_d, 5);
        ep_n = 1'b0; et_n = 1'b0; up = 1'b1;
        load_dec(3);
        check("R1 load over count", q_d, 3);
        ep_n = 1'b1; et_n = 1'b1;
    endtask

    task automatic test_dec_up();
        load_dec(0);
        ep_n = 1'b0; et_n = 1'b0; up = 1'b1;
        for (int i = 1; i <= 12; i++) begin
            step();
            check("R10 decimal up sequence", q_d, i % 10);
            check("R7 tc at 9 counting up", tc_d, (i % 10 == 9) ? 0 : 1);
            if (i % 10 == 9) begin
                ep_n = 1'b1; #1;
                check("R6 tc ignores parallel enable", tc_d, 0);
                step();
                check("R4 hold with parallel enable high", q_d, 9);
                et_n = 1'b1; #1;
                check("R5 tc gated by trickle enable", tc_d, 1);
                ep_n = 1'b0; step();
                check("R4 hold with trickle enable high", q_d, 9);
                et_n = 1'b0;
            end
        end
    endtask

    task automatic test_dec_down();
        load_dec(9);
        ep_n = 1'b0; et_n = 1'b0; up = 1'b0;
        for (int i = 1; i <= 12; i++) begin
            step();
            check("R11 decimal down sequence", q_d, ((9 - i) % 10 + 10) % 10);
            check("R8 tc at 0 counting down", tc_d, (q_d == 0) ? 0 : 1);
        end
        ep_n = 1'b1; et_n = 1'b1;
    endtask

    task automatic test_illegal();
        for (int c = 10; c <= 14; c += 2) begin
            load_dec(c);
            ep_n = 1'b0; et_n = 1'b0; up = 1'b1;
            step();
            check("R13 even unused code steps up", q_d, c + 1);
            check("R12 tc low at odd unused code", tc_d, 0);
            step();
            check("R13 odd unused code goes to 0", q_d, 0);
            ep_n = 1'b1; et_n = 1'b1;
        end
        for (int c = 10; c <= 15; c++) begin
            load_dec(c);
            ep_n = 1'b0; et_n = 1'b0; up = 1'b0;
            step();
            check("R13 unused code counts down to 9", q_d, 9);
            ep_n = 1'b1; et_n = 1'b1;
        end
    endtask

    task automatic chain_run(input int start, input bit dir, input int n);
        int ref_v = start;
        c_load_n = 1'b0; c_din = 8'(start);
        step();
        c_load_n = 1'b1; c_en_n = 1'b0; c_up = dir;
        for (int i = 0; i < n; i++) begin
            check(dir ? "R7 chain carry-out at 255" : "R8 chain borrow-out at 0",
                  tc_hi, (dir ? (ref_v == 255) : (ref_v == 0)) ? 0 : 1);
            step();
            ref_v = dir ? (ref_v + 1) % 256 : (ref_v + 255) % 256;
            check(dir ? "R2 R9 chained binary up" : "R3 R9 chained binary down",
                  {q_hi, q_lo}, ref_v);
        end
        c_en_n = 1'b1;
        step();
        check("R4 chain holds when disabled", {q_hi, q_lo}, ref_v);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        @(negedge clk);
        test_reset();
        test_load();
        test_dec_up();
        test_dec_down();
        test_illegal();
        chain_run(8'hF8 - 8'd0, 1'b1, 24);
        chain_run(5, 1'b0, 24);
        chain_run(8'h2E, 1'b1, 40);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule